// File: doc/BRIEF.md
# I2C Slave Transmitter Status Engine

This block answers read requests on a two-wire bus as a slave. It watches the clock and data wires through synchronizers and pulls the data wire low through an output enable. Its firmware side is a set of simple strobes and levels. Firmware can set the device address and the acknowledge enable, load the next transmit byte, read an 8-bit event code and clear the event flag. After a bus error, firmware can also ask for recovery.

Each protocol event raises the flag and loads a fixed code. While the flag is set, the slave holds the clock wire low. Firmware answers by loading data and clearing the flag. Write requests and foreign addresses are ignored. Firmware can drop the acknowledge enable before the final byte. The slave then sends that byte and afterwards leaves the data wire released, so the master reads all-ones from then on. A START or STOP in the middle of a byte or acknowledge slot is reported as a bus error. Recovery returns the slave to the idle state without driving a STOP.

Top module: `i2c_slv_tx_status`

## Requirements
- R1: A START, then the own 7-bit address with read bit 1, makes the slave pull SDA low in the ninth clock. It then sets the flag with code 0xA8.
- R2: A foreign address, or the own address with read bit 0, gets no ACK (SDA stays high in the ninth clock). It sets no flag and leaves the code at 0xF8.
- R3: If `arb_lost_i` pulsed since the last addressing, a matching read request reports 0xB0 instead of 0xA8.
- R4: The loaded byte goes out MSB first. SDA only changes while SCL is low, and the master's ACK/NACK is sampled at the ninth SCL rise.
- R5: A byte answered with ACK reports 0xB8, and the slave stays addressed for another byte.
- R6: A byte answered with NACK reports 0xC0, and the slave returns to not-addressed.
- R7: If `ack_en_i` was 0 when the byte was loaded, an ACKed byte reports 0xC8. After that the slave drives nothing, the master reads 0xFF, and no further flag is raised.
- R8: Whenever the flag is clear, `status_o` shows 0xF8.
- R9: A START or STOP during an address byte (after its first bit), a data byte or an acknowledge slot sets the flag with code 0x00.
- R10: In the error state, a control write with both clear and stop set does four things: it clears the flag, releases SDA and SCL, and sends no STOP. It also returns the slave to idle, so a later read request is answered again.
- R11: SCL is held low (`scl_oe_o` = 1) from one cycle after the flag is set until one cycle after firmware clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL wire level |
| sda_i | input | 1 | Sensed SDA wire level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Own slave address |
| ack_en_i | input | 1 | Acknowledge enable; sampled when a byte is loaded |
| tx_wr_i | input | 1 | Strobe: store `tx_data_i` as next transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| ctl_wr_i | input | 1 | Strobe: control write |
| ctl_clr_i | input | 1 | With `ctl_wr_i`: clear the flag |
| ctl_stop_i | input | 1 | With `ctl_wr_i` and `ctl_clr_i`: bus error recovery; self-clearing |
| arb_lost_i | input | 1 | Pulse: an arbitration loss occurred |
| flag_o | output | 1 | Event flag |
| status_o | output | 8 | Event code, 0xF8 when the flag is clear |

## Verification
The hardest case to reach is the bus error. A well-behaved master never puts a START or STOP inside a byte, so the bench master is made to misbehave on purpose. It sends a START and three address bits, then raises SDA while SCL is high. The bench then checks the 0x00 code and the stretched SCL. It issues the combined clear-and-stop write and confirms that SDA stays released. Finally it runs a new read request to show that the slave is answering again. The all-ones tail after 0xC8 is also covered: the bench drops the acknowledge enable at load time and then clocks one more full byte.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_TX, ST_WACK, ST_ONES, ST_ERR
  } stx_state_e;

  localparam logic [7:0] CODE_ADDRESSED = 8'hA8;
  localparam logic [7:0] CODE_ARB_ADDR  = 8'hB0;
  localparam logic [7:0] CODE_SENT_ACK  = 8'hB8;
  localparam logic [7:0] CODE_SENT_NACK = 8'hC0;
  localparam logic [7:0] CODE_LAST_ACK  = 8'hC8;
  localparam logic [7:0] CODE_NONE      = 8'hF8;
  localparam logic [7:0] CODE_BUS_ERR   = 8'h00;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_hi    = scl_pipe[STAGES-1];
  assign sda_hi    = sda_pipe[STAGES-1];
  assign scl_rise  = scl_hi & ~scl_d;
  assign scl_fall  = ~scl_hi & scl_d;
  assign bus_start = scl_hi & scl_d & sda_d & ~sda_hi;
  assign bus_stop  = scl_hi & scl_d & ~sda_d & sda_hi;
endmodule

// File: rtl/i2c_stx_core.sv
module i2c_stx_core
  import i2c_stx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_hi,
  input  logic              sda_hi,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ctl_wr,
  input  logic              ctl_clr,
  input  logic              ctl_stop,
  input  logic              arb_lost,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              flag,
  output logic [7:0]        status
);
  localparam int CW = $clog2(DATA_W + 1);

  stx_state_e        st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic [ADDR_W-1:0] ash;
  logic              arb_seen, last_byte, acked;
  logic              in_frame, err_now, addr_hit;

  assign in_frame = (st == ST_ADDR && cnt != '0) || st == ST_AACK ||
                    (st == ST_TX && cnt != '0) || st == ST_WACK;
  assign err_now  = (bus_start | bus_stop) & in_frame;
  assign addr_hit = ({ash, sda_hi} == {own_addr, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      ash       <= '0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      flag      <= 1'b0;
      status    <= CODE_NONE;
      arb_seen  <= 1'b0;
      last_byte <= 1'b0;
      acked     <= 1'b0;
    end else begin
      scl_oe <= flag;
      if (arb_lost) arb_seen <= 1'b1;

      if (ctl_wr && ctl_clr && flag) begin
        flag   <= 1'b0;
        status <= CODE_NONE;
        if (st == ST_TX) begin
          sh        <= tx_byte;
          sda_oe    <= ~tx_byte[DATA_W-1];
          last_byte <= ~ack_en;
        end
        if (ctl_stop && st == ST_ERR) begin
          st     <= ST_IDLE;
          sda_oe <= 1'b0;
        end
      end

      if (err_now) begin
        st     <= ST_ERR;
        flag   <= 1'b1;
        status <= CODE_BUS_ERR;
        sda_oe <= 1'b0;
      end else if (bus_start && st != ST_ERR) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop && st != ST_ERR) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            ash <= {ash[ADDR_W-2:0], sda_hi};
            cnt <= cnt + CW'(1);
            if (cnt == CW'(ADDR_W)) st <= addr_hit ? ST_AACK : ST_IDLE;
          end
          ST_AACK: if (scl_fall) begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else begin
              sda_oe   <= 1'b0;
              st       <= ST_TX;
              cnt      <= '0;
              flag     <= 1'b1;
              status   <= arb_seen ? CODE_ARB_ADDR : CODE_ADDRESSED;
              arb_seen <= 1'b0;
            end
          end
          ST_TX: if (scl_fall && !flag) begin
            if (cnt == CW'(DATA_W - 1)) begin
              st     <= ST_WACK;
              sda_oe <= 1'b0;
              cnt    <= '0;
            end else begin
              sh     <= sh << 1;
              sda_oe <= ~sh[DATA_W-2];
              cnt    <= cnt + CW'(1);
            end
          end
          ST_WACK: begin
            if (scl_rise) acked <= ~sda_hi;
            if (scl_fall) begin
              flag <= 1'b1;
              cnt  <= '0;
              if (!acked) begin
                status <= CODE_SENT_NACK;
                st     <= ST_IDLE;
              end else if (last_byte) begin
                status <= CODE_LAST_ACK;
                st     <= ST_ONES;
              end else begin
                status <= CODE_SENT_ACK;
                st     <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: data wire changes only while the sensed clock is low
  p_sda_change_low_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && $past(st) == ST_TX && !$stable(sda_oe)) |-> !$past(scl_hi));

  // R11: a set flag holds the clock low on the next cycle
  p_stretch_r11: assert property (@(posedge clk) disable iff (rst)
    flag |=> scl_oe);

  // R8: idle code whenever no event is pending
  p_idle_code_r8: assert property (@(posedge clk) disable iff (rst)
    !flag |-> status == CODE_NONE);

  // R9: start/stop inside an address byte raises the error code
  p_addr_err_r9: assert property (@(posedge clk) disable iff (rst)
    ((bus_start || bus_stop) && st == ST_ADDR && cnt != '0) |=>
      (flag && status == CODE_BUS_ERR));

  // R10: recovery write leaves the bus released and the slave idle
  p_recover_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERR && flag && ctl_wr && ctl_clr && ctl_stop && !bus_start && !bus_stop) |=>
      (!flag && !sda_oe && st == ST_IDLE));
endmodule

// File: rtl/i2c_slv_tx_status.sv
module i2c_slv_tx_status #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_clr_i,
  input  logic              ctl_stop_i,
  input  logic              arb_lost_i,
  output logic              flag_o,
  output logic [7:0]        status_o
);
  logic scl_hi, sda_hi, scl_rise, scl_fall, bus_start, bus_stop;
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst)          tx_q <= '0;
    else if (tx_wr_i) tx_q <= tx_data_i;
  end

  i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_stx_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .scl_hi(scl_hi), .sda_hi(sda_hi),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .own_addr(own_addr_i), .ack_en(ack_en_i), .tx_byte(tx_q),
    .ctl_wr(ctl_wr_i), .ctl_clr(ctl_clr_i), .ctl_stop(ctl_stop_i),
    .arb_lost(arb_lost_i),
    .sda_oe(sda_oe_o), .scl_oe(scl_oe_o), .flag(flag_o), .status(status_o)
  );
endmodule

// File: tb/tb_i2c_slv_tx_status.sv
`timescale 1ns/1ps
module tb_i2c_slv_tx_status;
  localparam int T = 20;
  localparam logic [6:0] OWN = 7'h35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl, sda;
  logic scl_oe, sda_oe, flag;
  logic [7:0] status;
  logic [6:0] own_addr = OWN;
  logic ack_en = 1'b1, tx_wr = 1'b0, ctl_wr = 1'b0, ctl_clr = 1'b0, ctl_stop = 1'b0, arb_lost = 1'b0;
  logic [7:0] tx_data = 8'h00;

  assign scl = m_scl & ~scl_oe;
  assign sda = m_sda & ~sda_oe;

  i2c_slv_tx_status dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .own_addr_i(own_addr), .ack_en_i(ack_en), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .ctl_wr_i(ctl_wr), .ctl_clr_i(ctl_clr), .ctl_stop_i(ctl_stop), .arb_lost_i(arb_lost),
    .flag_o(flag), .status_o(status)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic flag_prev = 1'b0;
  logic done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [7:0] c);
    case (c)
      8'hA8: return "R1";  8'hB0: return "R3";  8'hB8: return "R5";
      8'hC0: return "R6";  8'hC8: return "R7";  8'h00: return "R9";
      default: return "R2";
    endcase
  endfunction

  // scoreboard monitor: every flag rise is matched against the expected code queue
  always @(negedge clk) begin
    if (!rst && flag && !flag_prev) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected flag", {24'h0, status}, 32'hF8);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(req_of(e), {24'h0, status}, {24'h0, e});
      end
    end
    flag_prev = flag;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl_high(); while (!scl) @(negedge clk); endtask
  task automatic expect_code(logic [7:0] c); exp_q.push_back(c); endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(T);
    m_sda = 1'b0; tick(T);
    m_scl = 1'b0; tick(T);
  endtask
  task automatic m_stop();
    m_sda = 1'b0; tick(T);
    m_scl = 1'b1; wait_scl_high(); tick(T);
    m_sda = 1'b1; tick(T);
  endtask
  task automatic m_wbit(logic b);
    m_sda = b; tick(T);
    m_scl = 1'b1; wait_scl_high(); tick(T);
    m_scl = 1'b0; tick(T);
  endtask
  task automatic m_rbit(output logic b);
    m_sda = 1'b1; tick(T);
    m_scl = 1'b1; wait_scl_high(); tick(T/2);
    b = sda; tick(T/2);
    m_scl = 1'b0; tick(T);
  endtask
  task automatic m_wbyte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
  endtask
  task automatic m_rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      m_rbit(b);
      v[i] = b;
    end
  endtask

  task automatic fw_load(logic [7:0] d, logic ae);
    tx_data = d; ack_en = ae; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask
  task automatic fw_clear(logic stop);
    ctl_wr = 1'b1; ctl_clr = 1'b1; ctl_stop = stop; tick(1);
    ctl_wr = 1'b0; ctl_clr = 1'b0; ctl_stop = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] v;
    tick(5); rst = 1'b0; tick(5);

    // R8 reset state
    check("R8 reset code", {24'h0, status}, 32'hF8);
    check("R8 reset flag", {31'h0, flag}, 0);
    check("R11 reset scl_oe", {31'h0, scl_oe}, 0);

    // R2 foreign address read
    m_start(); m_wbyte({7'h22, 1'b1}); m_rbit(b);
    check("R2 foreign NACK", {31'h0, b}, 1);
    check("R2 foreign no flag", {31'h0, flag}, 0);
    m_stop();
    // R2 own address with write bit
    m_start(); m_wbyte({OWN, 1'b0}); m_rbit(b);
    check("R2 write NACK", {31'h0, b}, 1);
    check("R2 code unchanged", {24'h0, status}, 32'hF8);
    m_stop();

    // R1 own read request
    expect_code(8'hA8);
    m_start(); m_wbyte({OWN, 1'b1}); m_rbit(b);
    check("R1 address ACK", {31'h0, b}, 0);
    check("R1 flag set", {31'h0, flag}, 1);
    check("R11 scl held", {31'h0, scl_oe}, 1);
    fw_load(8'hA5, 1'b1); fw_clear(1'b0);
    check("R8 code after clear", {24'h0, status}, 32'hF8);
    check("R11 scl released", {31'h0, scl_oe}, 0);
    expect_code(8'hB8);
    m_rbyte(v);
    check("R4 first byte MSB first", {24'h0, v}, 32'hA5);
    m_wbit(1'b0);
    check("R5 flag after ACK", {31'h0, flag}, 1);
    fw_load(8'h3C, 1'b1); fw_clear(1'b0);
    expect_code(8'hC0);
    m_rbyte(v);
    check("R4 second byte", {24'h0, v}, 32'h3C);
    m_wbit(1'b1);
    check("R6 flag after NACK", {31'h0, flag}, 1);
    fw_clear(1'b0);
    m_stop();

    // R3 arbitration loss then addressed; R7 last byte
    arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
    expect_code(8'hB0);
    m_start(); m_wbyte({OWN, 1'b1}); m_rbit(b);
    check("R3 address ACK", {31'h0, b}, 0);
    fw_load(8'h81, 1'b0); fw_clear(1'b0);
    expect_code(8'hC8);
    m_rbyte(v);
    check("R7 last byte", {24'h0, v}, 32'h81);
    m_wbit(1'b0);
    check("R7 flag after last", {31'h0, flag}, 1);
    fw_clear(1'b0);
    m_rbyte(v);
    check("R7 all ones", {24'h0, v}, 32'hFF);
    m_wbit(1'b0);
    check("R7 no further flag", {31'h0, flag}, 0);
    m_stop();
    ack_en = 1'b1;

    // R9 bus error inside address byte
    expect_code(8'h00);
    m_start(); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
    m_stop();
    check("R9 error flag", {31'h0, flag}, 1);
    check("R9 error code", {24'h0, status}, 32'h00);
    check("R11 scl held on error", {31'h0, scl_oe}, 1);
    // R10 recovery
    fw_clear(1'b1);
    check("R10 flag cleared", {31'h0, flag}, 0);
    check("R10 sda released", {31'h0, sda_oe}, 0);
    check("R10 scl released", {31'h0, scl_oe}, 0);
    check("R10 no STOP driven", {31'h0, sda}, 1);
    expect_code(8'hA8);
    m_start(); m_wbyte({OWN, 1'b1}); m_rbit(b);
    check("R10 answers again", {31'h0, b}, 0);
    fw_load(8'h5A, 1'b1); fw_clear(1'b0);
    expect_code(8'hC0);
    m_rbyte(v);
    check("R4 byte after recovery", {24'h0, v}, 32'h5A);
    m_wbit(1'b1);
    fw_clear(1'b0);
    m_stop();

    tick(10);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule